// File: doc/BRIEF.md
# Selectable-Structure 16-bit Pseudo-Random Sequence Generator

This block is a 16-bit linear-feedback shift register built on the maximal-length polynomial x^16 + x^14 + x^13 + x^11 + 1. It produces a 16-bit state word and a one-bit pseudo-random stream. At run time, one input selects the feedback sense (exclusive-OR or its complement) and a second input selects the structure. The external-feedback structure gathers the taps into the top bit. The internal-feedback structure folds a mask into the shifted word.

The surrounding logic can do three things with the register: advance it one step, hold it, or load a 16-bit seed. The block knows which state locks up for the active feedback sense. It never loads that state, and it steps out of it if a change of mode leaves the register there. Because the reset value is all zeros, the register can run straight out of reset in either feedback sense without being seeded.

Top module: `lfsr16_gen`

## Requirements
- R1: Synchronous active-low reset sets the state to 0x0000, so the serial output is 0.
- R2: External-feedback, XOR sense (xnor_i=0, galois_i=0): the next state is {s[0]^s[2]^s[3]^s[5], s[15:1]}, so 0xACE1 is followed by 0x5670.
- R3: Internal-feedback, XOR sense (xnor_i=0, galois_i=1): the state shifts right by one and is XORed with 0xB400 when the bit shifted out is 1, so 0xACE1 is followed by 0xE270.
- R4: XNOR sense (xnor_i=1): the next state is the bitwise complement of the XOR-sense next state of the complemented current state. In external feedback, 0x531E is followed by 0xA98F and 0x0000 by 0x8000. In internal feedback, 0x531E is followed by 0x1D8F and 0x0000 by 0x3400.
- R5: With load_i and step_i both low, the state holds.
- R6: load_i takes priority over step_i, and a non-lockup seed is stored unchanged on the next edge.
- R7: A seed equal to the lockup state of the active sense (0x0000 for XOR, 0xFFFF for XNOR) is replaced by 0x0001 (XOR) or 0xFFFE (XNOR).
- R8: A step taken while the state equals the lockup state of the active sense moves the register to 0x0001 (XOR) or 0xFFFE (XNOR).
- R9: serial_o always equals bit 0 of state_o.
- R10: In every mode, a non-lockup start state recurs after exactly 65535 steps and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| step_i | input | 1 | Advance the register one step |
| load_i | input | 1 | Load seed_i (overrides step_i) |
| seed_i | input | 16 | Seed word |
| xnor_i | input | 1 | 0 = XOR feedback, 1 = XNOR feedback |
| galois_i | input | 1 | 0 = external feedback, 1 = internal feedback |
| state_o | output | 16 | Current register state |
| serial_o | output | 1 | Pseudo-random output bit (state bit 0) |

## Verification
Two functions can fall in the same cycle. A seed load can coincide with a step, and a step can coincide with lockup recovery. The first case is provoked by raising load_i and step_i together, and it passes only if the seed appears unchanged instead of the stepped value. The second case is provoked by loading 0xFFFF in XOR sense and then stepping with the sense switched to XNOR. The register must land on 0xFFFE rather than stay stuck, and the same recovery is checked for an XOR step taken straight out of the zero reset.

// File: rtl/lfsr16_pkg.sv
package lfsr16_pkg;

    localparam int unsigned LFSR_W = 16;

    typedef logic [LFSR_W-1:0] word_t;

    typedef enum logic {
        FB_XOR  = 1'b0,
        FB_XNOR = 1'b1
    } fb_kind_e;

    typedef enum logic {
        ARCH_FIB = 1'b0,
        ARCH_GAL = 1'b1
    } arch_e;

    typedef struct packed {
        word_t state;
    } lfsr_regs_t;

    // Mirror a word; turns the internal-feedback mask into external taps.
    function automatic word_t bit_rev(input word_t v);
        word_t r;
        for (int i = 0; i < LFSR_W; i++) begin
            r[i] = v[LFSR_W-1-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/lfsr16_step.sv
module lfsr16_step
    import lfsr16_pkg::*;
#(
    parameter word_t MASK = 16'hB400
) (
    input  word_t    cur_i,
    input  fb_kind_e kind_i,
    input  arch_e    arch_i,
    output word_t    nxt_o
);
    localparam word_t FIB_TAPS = bit_rev(MASK);

    word_t core;
    word_t fib_nxt;
    word_t gal_nxt;
    word_t pick;

    always_comb begin
        // XNOR sense is the XOR map conjugated by complement.
        core    = (kind_i == FB_XNOR) ? ~cur_i : cur_i;
        fib_nxt = {^(core & FIB_TAPS), core[LFSR_W-1:1]};
        gal_nxt = (core >> 1) ^ (core[0] ? MASK : '0);
        pick    = (arch_i == ARCH_GAL) ? gal_nxt : fib_nxt;
        nxt_o   = (kind_i == FB_XNOR) ? ~pick : pick;
    end

endmodule

// File: rtl/lfsr16_guard.sv
module lfsr16_guard
    import lfsr16_pkg::*;
(
    input  word_t    word_i,
    input  fb_kind_e kind_i,
    output word_t    safe_o
);
    localparam word_t ONE = word_t'(1);

    word_t lock_word;
    word_t rec_word;

    always_comb begin
        lock_word = (kind_i == FB_XNOR) ? '1 : '0;
        rec_word  = (kind_i == FB_XNOR) ? ~ONE : ONE;
        safe_o    = (word_i == lock_word) ? rec_word : word_i;
    end

endmodule

// File: rtl/lfsr16_gen.sv
module lfsr16_gen
    import lfsr16_pkg::*;
#(
    parameter word_t MASK    = 16'hB400,
    parameter word_t RST_VAL = '0
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        step_i,
    input  logic        load_i,
    input  logic [15:0] seed_i,
    input  logic        xnor_i,
    input  logic        galois_i,
    output logic [15:0] state_o,
    output logic        serial_o
);
    lfsr_regs_t q, d;

    fb_kind_e kind;
    arch_e    arch;
    word_t    nxt_w;
    word_t    seed_safe;
    word_t    cur_safe;

    assign kind = fb_kind_e'(xnor_i);
    assign arch = arch_e'(galois_i);

    lfsr16_step #(.MASK(MASK)) u_step (
        .cur_i  (q.state),
        .kind_i (kind),
        .arch_i (arch),
        .nxt_o  (nxt_w)
    );

    lfsr16_guard u_seed_guard (
        .word_i (seed_i),
        .kind_i (kind),
        .safe_o (seed_safe)
    );

    lfsr16_guard u_cur_guard (
        .word_i (q.state),
        .kind_i (kind),
        .safe_o (cur_safe)
    );

    always_comb begin
        d = q;
        if (load_i) begin
            d.state = seed_safe;
        end else if (step_i) begin
            // A substituted value means the register sits in lockup.
            d.state = (cur_safe != q.state) ? cur_safe : nxt_w;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q.state <= RST_VAL;
        end else begin
            q <= d;
        end
    end

    assign state_o  = q.state;
    assign serial_o = q.state[0];

endmodule

// File: rtl/lfsr16_chk.sv
module lfsr16_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        step_i,
    input logic        load_i,
    input logic [15:0] seed_i,
    input logic        xnor_i,
    input logic        galois_i,
    input logic [15:0] state_o,
    input logic        serial_o
);

    assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && !step_i) |=> $stable(state_o));

    assert_serial_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        serial_o == state_o[0]);

    assert_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i && seed_i != 16'h0000 && seed_i != 16'hFFFF) |=> state_o == $past(seed_i));

    assert_nolock_xor_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i && !xnor_i) |=> state_o != 16'h0000);

    assert_nolock_xnor_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i && xnor_i) |=> state_o != 16'hFFFF);

    assert_recover_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && !load_i && xnor_i && state_o == 16'hFFFF) |=> state_o == 16'hFFFE);

    assert_fib_shift_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && !load_i && !galois_i && !xnor_i && state_o != 16'h0000)
        |=> state_o[14:0] == $past(state_o[15:1]));

endmodule

bind lfsr16_gen lfsr16_chk u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (step_i),
    .load_i   (load_i),
    .seed_i   (seed_i),
    .xnor_i   (xnor_i),
    .galois_i (galois_i),
    .state_o  (state_o),
    .serial_o (serial_o)
);

// File: tb/tb_lfsr16_gen.sv
`timescale 1ns/1ps
module tb_lfsr16_gen;

    logic        clk = 1'b0;
    logic        rst_ni;
    logic        step_i, load_i, xnor_i, galois_i;
    logic [15:0] seed_i;
    logic [15:0] state_o;
    logic        serial_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    lfsr16_gen dut (
        .clk_i(clk), .rst_ni(rst_ni), .step_i(step_i), .load_i(load_i),
        .seed_i(seed_i), .xnor_i(xnor_i), .galois_i(galois_i),
        .state_o(state_o), .serial_o(serial_o)
    );

    // {load, step, xnor, galois, seed, expected state after the edge}
    localparam int NV = 17;
    localparam logic [35:0] VEC [NV] = '{
        {4'b1000, 16'hACE1, 16'hACE1},  // R6 load
        {4'b0100, 16'h0000, 16'h5670},  // R2 fib xor
        {4'b1000, 16'hACE1, 16'hACE1},  // R6
        {4'b0101, 16'h0000, 16'hE270},  // R3 galois xor
        {4'b0001, 16'h0000, 16'hE270},  // R5 hold
        {4'b1000, 16'h0000, 16'h0001},  // R7 xor lockup seed
        {4'b1010, 16'hFFFF, 16'hFFFE},  // R7 xnor lockup seed
        {4'b1010, 16'h0000, 16'h0000},  // R6 zero legal in xnor
        {4'b0110, 16'h0000, 16'h8000},  // R4 fib xnor from zero
        {4'b1100, 16'h1234, 16'h1234},  // R6 load beats step
        {4'b1000, 16'hFFFF, 16'hFFFF},  // R6 all ones legal in xor
        {4'b0110, 16'h0000, 16'hFFFE},  // R8 recovery after sense switch
        {4'b1011, 16'h0000, 16'h0000},  // R6
        {4'b0111, 16'h0000, 16'h3400},  // R4 galois xnor from zero
        {4'b1010, 16'h531E, 16'h531E},  // R6
        {4'b0110, 16'h0000, 16'hA98F},  // R4 fib xnor complement
        {4'b1011, 16'h531E, 16'h531E}   // R6
    };

    function automatic logic [15:0] model(input logic [15:0] s, input bit xn, input bit gal);
        logic fb;
        if (!gal) begin
            fb = s[0] ^ s[2] ^ s[3] ^ s[5];
            if (xn) fb = ~fb;
            return {fb, s[15:1]};
        end else if (!xn) begin
            return s[0] ? ((s >> 1) ^ 16'hB400) : (s >> 1);
        end else begin
            return s[0] ? ((s >> 1) | 16'h8000) : (((s >> 1) | 16'h8000) ^ 16'hB400);
        end
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_period(input string req, input logic [15:0] seed, input bit xn,
                              input bit gal, input int limit, input bit full);
        logic [15:0] m;
        int          first_ret;
        bit          model_ok;
        @(negedge clk);
        load_i = 1'b1; step_i = 1'b0; xnor_i = xn; galois_i = gal; seed_i = seed;
        @(negedge clk);
        load_i = 1'b0; step_i = 1'b1;
        m = seed; first_ret = 0; model_ok = 1'b1;
        for (int n = 1; n <= limit; n++) begin
            @(negedge clk);
            m = model(m, xn, gal);
            if (state_o !== m || serial_o !== m[0]) model_ok = 1'b0;
            if (state_o === seed && first_ret == 0) first_ret = n;
        end
        step_i = 1'b0;
        check({req, " R4 sequence"}, {15'd0, model_ok}, 16'd1);
        if (full) check({req, " R10 period"}, 16'(first_ret), 16'hFFFF);
        else      check({req, " R10 no early repeat"}, 16'(first_ret), 16'd0);
    endtask

    initial begin
        rst_ni = 1'b0; step_i = 1'b0; load_i = 1'b0;
        xnor_i = 1'b0; galois_i = 1'b0; seed_i = '0;
        repeat (3) @(negedge clk);
        check("R1 reset state", state_o, 16'h0000);
        check("R1 reset serial", {15'd0, serial_o}, 16'd0);
        rst_ni = 1'b1;

        // R8: XOR step straight from zero reset recovers
        step_i = 1'b1;
        @(negedge clk);
        check("R8 step from zero", state_o, 16'h0001);
        step_i = 1'b0;

        for (int i = 0; i < NV; i++) begin
            {load_i, step_i, xnor_i, galois_i, seed_i} = VEC[i][35:16];
            @(negedge clk);
            check($sformatf("vec%0d R2-R8 table", i), state_o, VEC[i][15:0]);
            check($sformatf("vec%0d R9 serial", i), {15'd0, serial_o}, {15'd0, VEC[i][0]});
        end
        // last entry left galois xnor seed 531E: one step gives 1D8F (R4)
        load_i = 1'b0; step_i = 1'b1;
        @(negedge clk);
        check("R4 galois xnor complement", state_o, 16'h1D8F);
        step_i = 1'b0;

        run_period("fib xor",    16'hACE1, 1'b0, 1'b0, 65535, 1'b1);
        run_period("galois xnor", 16'h0000, 1'b1, 1'b1, 65535, 1'b1);
        run_period("fib xnor",   16'h531E, 1'b1, 1'b0, 3000, 1'b0);
        run_period("galois xor", 16'hACE1, 1'b0, 1'b1, 3000, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule